// File: doc/BRIEF.md
# Dual-Source Stream Switch with Failover

This block forwards one of two incoming data streams into a separate output clock domain. Each stream arrives with its own clock, a data word and a valid strobe. Each stream is written into its own asynchronous FIFO. The output domain reads only from the FIFO that is currently selected. The selection is held in a control clock domain. It follows a request input, except when the primary source (index 0) has lost its clock. In that case the block moves to the backup source (index 1) by itself, and it moves back once the primary clock returns.

Any change of the active source starts a flush. Both FIFOs are reset on both of their sides through per-domain reset synchronizers. The output then stays silent for a fixed settling window before it resumes reading. Data around a switchover may be lost; words that are forwarded are never reordered or mixed. The FIFO that is not selected is still written. It fills and drops words, and a sticky overflow flag in its write domain records this until the next flush clears it.

Top module: `stream_failover_switch`

## Requirements
- R1: While reset is held and just after it is released, out_valid is 0, active_src is 0 and both overflow flags are 0.
- R2: When the source 0 clock is running, active_src takes the value of sel_req within 3 control-clock cycles.
- R3: Every word presented with out_valid comes from the active source. In the test pattern, bit 7 is the source index. Words from one source arrive in write order, so the low 7 bits of back-to-back words from the same stream increase by exactly 1 (mod 128).
- R4: After each change of active_src, out_valid stays 0 for at least 16 output-clock cycles. Forwarding then resumes within 100 output-clock cycles.
- R5: Words written into a full FIFO are dropped, and that FIFO's overflow flag sets and stays 1. A stream that is not selected overflows in this way without disturbing the output stream.
- R6: A flush clears both overflow flags. A selected source whose write rate is below the output read rate keeps its flag at 0.
- R7: If no source 0 clock activity is seen for 256 control cycles, active_src becomes 1 whatever sel_req is. It is not declared earlier than that.
- R8: When the source 0 clock resumes, active_src returns to sel_req, and source 0 words are forwarded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ctl_clk | input | 1 | Control-domain clock |
| sel_req | input | 1 | Requested source index (control domain) |
| active_src | output | 1 | Source index in use (control domain) |
| s0_clk | input | 1 | Primary source clock |
| s0_valid | input | 1 | Primary source word strobe |
| s0_data | input | 8 | Primary source word |
| s0_overflow | output | 1 | Sticky drop flag, primary write domain |
| s1_clk | input | 1 | Backup source clock |
| s1_valid | input | 1 | Backup source word strobe |
| s1_data | input | 8 | Backup source word |
| s1_overflow | output | 1 | Sticky drop flag, backup write domain |
| out_clk | input | 1 | Output-domain clock |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 8 | Output word |

## Verification
Two actions can land in the same control cycle: a new selection and a flush that is still running from the previous one. The bench provokes this by flipping sel_req 0, 1, 0 on consecutive control cycles. It then checks that the flush window restarts, with at least 16 silent output cycles, and that the stream resumes from source 0 in order. A second case lines up a clock-loss failover against requests that point back at source 0. The bench checks that the loss overrides the request and that only backup words appear until the primary clock is restored.

// File: rtl/sfs_pkg.sv
`timescale 1ns/1ps
package sfs_pkg;
  localparam logic SRC_PRIMARY = 1'b0;
  localparam logic SRC_BACKUP  = 1'b1;

  // Source to use: the request, overridden by primary clock loss
  function automatic logic pick_source(input logic req, input logic primary_lost);
    return primary_lost ? SRC_BACKUP : req;
  endfunction

  // Width of a counter that must hold the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sync2.sv
`timescale 1ns/1ps
module sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage  <= 1'b1;
      srst_n <= stage;
    end
  end
endmodule

// File: rtl/clk_loss_det.sv
`timescale 1ns/1ps
module clk_loss_det #(
  parameter int unsigned LIMIT = 256
) (
  input  logic src_clk,
  input  logic src_arst_n,
  input  logic mon_clk,
  input  logic mon_rst_n,
  output logic lost
);
  import sfs_pkg::*;
  localparam int unsigned CW = cnt_width(LIMIT);

  logic          beat;
  logic          beat_s;
  logic          beat_d;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge src_clk or negedge src_arst_n) begin
    if (!src_arst_n) beat <= 1'b0;
    else             beat <= ~beat;
  end

  sync2 u_beat_sync (.clk(mon_clk), .rst_n(mon_rst_n), .d(beat), .q(beat_s));

  assign lost = (idle_cnt == CW'(LIMIT));

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      beat_d   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      beat_d <= beat_s;
      if (beat_s != beat_d) idle_cnt <= '0;
      else if (!lost)       idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/async_fifo.sv
`timescale 1ns/1ps
module async_fifo #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wvalid,
  input  logic [DW-1:0] wdata,
  output logic          overflow,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, rbin, wgray, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic          full, wr_go, rd_go;

  assign wgray = to_gray(wbin);
  assign rgray = to_gray(rbin);
  assign full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign empty = (rgray == wq2);
  assign wr_go = wvalid & ~full;
  assign rd_go = rd & ~empty;
  assign rdata = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      rq1      <= '0;
      rq2      <= '0;
      overflow <= 1'b0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go)           wbin     <= wbin + 1'b1;
      if (wvalid && full)  overflow <= 1'b1;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0;
      wq1  <= '0;
      wq2  <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_go) rbin <= rbin + 1'b1;
    end
  end
endmodule

// File: rtl/stream_failover_switch.sv
`timescale 1ns/1ps
module stream_failover_switch #(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 4,
  parameter int unsigned LOSS_LIMIT = 256,
  parameter int unsigned HOLD_CYC   = 16,
  parameter int unsigned FLUSH_CYC  = 8
) (
  input  logic          rst_n,
  input  logic          ctl_clk,
  input  logic          sel_req,
  output logic          active_src,
  input  logic          s0_clk,
  input  logic          s0_valid,
  input  logic [DW-1:0] s0_data,
  output logic          s0_overflow,
  input  logic          s1_clk,
  input  logic          s1_valid,
  input  logic [DW-1:0] s1_data,
  output logic          s1_overflow,
  input  logic          out_clk,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  import sfs_pkg::*;
  localparam int unsigned NSRC = 2;
  localparam int unsigned FL_W = cnt_width(FLUSH_CYC);
  localparam int unsigned HD_W = cnt_width(HOLD_CYC);

  // ---------------- control domain ----------------
  logic            ctl_rst_n;
  logic            src0_lost;
  logic            eff_sel;
  logic [FL_W-1:0] flush_cnt;
  logic            flush_req;
  logic            dom_arst_n;

  rst_sync u_ctl_rst (.clk(ctl_clk), .arst_n(rst_n), .srst_n(ctl_rst_n));

  clk_loss_det #(.LIMIT(LOSS_LIMIT)) u_loss (
    .src_clk(s0_clk), .src_arst_n(rst_n),
    .mon_clk(ctl_clk), .mon_rst_n(ctl_rst_n), .lost(src0_lost)
  );

  assign eff_sel   = pick_source(sel_req, src0_lost);
  assign flush_req = (flush_cnt != '0);

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      active_src <= SRC_PRIMARY;
      flush_cnt  <= '0;
    end else if (eff_sel != active_src) begin
      active_src <= eff_sel;
      flush_cnt  <= FL_W'(FLUSH_CYC);
    end else if (flush_req) begin
      flush_cnt  <= flush_cnt - 1'b1;
    end
  end

  // Reset source for every flushed domain
  assign dom_arst_n = rst_n & ~flush_req;

  // ---------------- output domain control ----------------
  logic            out_rrst_n;
  logic            sel_o;
  logic [HD_W-1:0] hold_cnt;
  logic            hold_done;
  logic            rd_ok;
  logic [NSRC-1:0] src_clk, src_valid, src_ovf, wr_rst_n, fifo_empty, fifo_rd;
  logic [DW-1:0]   src_data   [NSRC];
  logic [DW-1:0]   fifo_rdata [NSRC];

  rst_sync u_out_rst (.clk(out_clk), .arst_n(dom_arst_n), .srst_n(out_rrst_n));
  sync2    u_sel_o   (.clk(out_clk), .rst_n(out_rrst_n), .d(active_src), .q(sel_o));

  assign hold_done = (hold_cnt == HD_W'(HOLD_CYC));
  assign rd_ok     = hold_done & ~fifo_empty[sel_o];

  // ---------------- per-source paths ----------------
  assign src_clk   = {s1_clk, s0_clk};
  assign src_valid = {s1_valid, s0_valid};
  assign src_data[0] = s0_data;
  assign src_data[1] = s1_data;
  assign s0_overflow = src_ovf[0];
  assign s1_overflow = src_ovf[1];

  for (genvar k = 0; k < NSRC; k++) begin : g_path
    rst_sync u_wr_rst (.clk(src_clk[k]), .arst_n(dom_arst_n), .srst_n(wr_rst_n[k]));

    assign fifo_rd[k] = rd_ok & (sel_o == k[0]);

    async_fifo #(.DW(DW), .AW(AW)) u_fifo (
      .wclk(src_clk[k]), .wrst_n(wr_rst_n[k]), .wvalid(src_valid[k]),
      .wdata(src_data[k]), .overflow(src_ovf[k]),
      .rclk(out_clk), .rrst_n(out_rrst_n), .rd(fifo_rd[k]),
      .rdata(fifo_rdata[k]), .empty(fifo_empty[k])
    );
  end

  always_ff @(posedge out_clk or negedge out_rrst_n) begin
    if (!out_rrst_n) begin
      hold_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
      out_valid <= rd_ok;
      out_data  <= fifo_rdata[sel_o];
    end
  end
endmodule

// File: rtl/stream_failover_switch_chk.sv
`timescale 1ns/1ps
module stream_failover_switch_chk (
  input logic rst_n,
  input logic ctl_clk,
  input logic out_clk,
  input logic active_src,
  input logic flush_req,
  input logic src0_lost,
  input logic out_valid,
  input logic out_rrst_n,
  input logic hold_done
);
  // R4
  flush_on_switch_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (active_src != $past(active_src)) |-> flush_req);

  // R7
  loss_forces_backup_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    src0_lost |=> active_src);

  // R4
  flush_blanks_output_chk: assert property (@(posedge out_clk) disable iff (!rst_n)
    !out_rrst_n |=> !out_valid);

  // R4
  valid_after_hold_chk: assert property (@(posedge out_clk) disable iff (!rst_n)
    out_valid |-> hold_done);
endmodule

bind stream_failover_switch stream_failover_switch_chk u_chk (
  .rst_n(rst_n), .ctl_clk(ctl_clk), .out_clk(out_clk),
  .active_src(active_src), .flush_req(flush_req), .src0_lost(src0_lost),
  .out_valid(out_valid), .out_rrst_n(out_rrst_n), .hold_done(hold_done)
);

// File: tb/test_stream_failover_switch.sv
`timescale 1ns/1ps
module test_stream_failover_switch;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b0, s0_clk = 1'b0, s1_clk = 1'b0, out_clk = 1'b0;
  logic s0_run = 1'b1;
  logic sel_req = 1'b0;
  logic active_src, s0_overflow, s1_overflow, out_valid;
  logic s0_valid = 1'b0, s1_valid = 1'b0;
  logic [7:0] s0_data = '0, s1_data = '0, out_data;

  int nvec = 0, nfail = 0;
  int words0 = 0, words1 = 0;
  bit mon_en = 0, done = 0;

  always #2.5  ctl_clk = ~ctl_clk;
  always #3.25 s1_clk  = ~s1_clk;
  always #2.75 out_clk = ~out_clk;
  always #3    s0_clk  = s0_run ? ~s0_clk : 1'b0;

  stream_failover_switch i_stream_failover_switch (
    .rst_n(rst_n), .ctl_clk(ctl_clk), .sel_req(sel_req), .active_src(active_src),
    .s0_clk(s0_clk), .s0_valid(s0_valid), .s0_data(s0_data), .s0_overflow(s0_overflow),
    .s1_clk(s1_clk), .s1_valid(s1_valid), .s1_data(s1_data), .s1_overflow(s1_overflow),
    .out_clk(out_clk), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sources: valid on every other cycle, bit 7 = source index, low 7 bits count
  initial begin
    logic [6:0] c0 = '0;
    forever begin
      @(negedge s0_clk);
      s0_valid = ~s0_valid;
      if (s0_valid) begin s0_data = {1'b0, c0}; c0++; end
    end
  end
  initial begin
    logic [6:0] c1 = '0;
    forever begin
      @(negedge s1_clk);
      s1_valid = ~s1_valid;
      if (s1_valid) begin s1_data = {1'b1, c1}; c1++; end
    end
  end

  // Output monitor (R3)
  initial begin
    logic last_act = 1'b0;
    int since = 0, gap = 0;
    bit have_prev = 0;
    logic [7:0] prev = '0;
    forever begin
      @(negedge out_clk);
      if (active_src != last_act) since = 0; else since++;
      last_act = active_src;
      if (mon_en && out_valid) begin
        gap = 0;
        if (since >= 8) begin
          chk(out_data[7] == active_src, "R3 source tag", out_data[7], active_src);
          if (out_data[7]) words1++; else words0++;
        end
        if (have_prev && out_data[7] == prev[7])
          chk(out_data[6:0] == prev[6:0] + 7'd1, "R3 order", out_data[6:0], prev[6:0] + 7'd1);
        prev = out_data;
        have_prev = 1;
      end else begin
        gap++;
        if (gap >= 10) have_prev = 0;
      end
    end
  end

  task automatic ctl_wait(input int n);
    repeat (n) @(negedge ctl_clk);
  endtask

  // Count silent output cycles until forwarding resumes (R4)
  task automatic measure_resume(input string tag);
    int n = 0;
    forever begin
      @(negedge out_clk);
      n++;
      if (out_valid || n > 300) break;
    end
    chk(n >= 16 && n <= 100, tag, n, 16);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w0, w1;
    ctl_wait(6);
    // R1 during reset
    chk(out_valid == 0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    ctl_wait(3);
    chk(out_valid == 0, "R1 valid after reset", out_valid, 0);
    chk(active_src == 0, "R1 active", active_src, 0);
    chk(s0_overflow == 0, "R1 s0 overflow", s0_overflow, 0);
    chk(s1_overflow == 0, "R1 s1 overflow", s1_overflow, 0);
    mon_en = 1;

    ctl_wait(400);
    chk(words0 > 50, "R3 primary forwarded", words0, 50);
    chk(s1_overflow == 1, "R5 unselected overflow", s1_overflow, 1);
    chk(s0_overflow == 0, "R6 selected no overflow", s0_overflow, 0);

    // Manual switch to backup
    sel_req = 1'b1;
    ctl_wait(3);
    chk(active_src == 1, "R2 follow request", active_src, 1);
    measure_resume("R4 resume after switch to 1");
    w1 = words1;
    ctl_wait(300);
    chk(s1_overflow == 0, "R6 flush clears s1 flag", s1_overflow, 0);
    chk(s0_overflow == 1, "R5 s0 overflow while idle", s0_overflow, 1);
    chk(words1 > w1 + 30, "R3 backup forwarded", words1, w1 + 30);

    // Request flips during a running flush
    sel_req = 1'b0;
    ctl_wait(1);
    sel_req = 1'b1;
    ctl_wait(1);
    sel_req = 1'b0;
    ctl_wait(3);
    chk(active_src == 0, "R2 final request", active_src, 0);
    measure_resume("R4 resume after back-to-back");
    w0 = words0;
    ctl_wait(300);
    chk(s0_overflow == 0, "R6 flush clears s0 flag", s0_overflow, 0);
    chk(words0 > w0 + 30, "R3 primary again", words0, w0 + 30);

    // Primary clock loss
    s0_run = 1'b0;
    ctl_wait(230);
    chk(active_src == 0, "R7 not declared early", active_src, 0);
    ctl_wait(70);
    chk(active_src == 1, "R7 failover", active_src, 1);
    sel_req = 1'b1;
    ctl_wait(5);
    sel_req = 1'b0;
    ctl_wait(5);
    chk(active_src == 1, "R7 request overridden", active_src, 1);
    w1 = words1;
    ctl_wait(200);
    chk(words1 > w1 + 20, "R7 backup stream", words1, w1 + 20);

    // Primary returns
    s0_run = 1'b1;
    ctl_wait(20);
    chk(active_src == 0, "R8 revert", active_src, 0);
    w0 = words0;
    ctl_wait(300);
    chk(words0 > w0 + 30, "R8 primary resumed", words0, w0 + 30);

    finish_run();
  end
endmodule